// File: doc/BRIEF.md
# DSP Block-Transfer DMA Engine

This engine copies blocks of 16-bit words between a DSP's local memories and a larger main memory. Software sets it up through five 16-bit registers on a small write port. These registers hold the main-memory byte address (upper and lower halves), the DSP word address, a control word and a byte count. Writing the byte count launches the copy. The control word chooses which DSP memory takes part (data or instruction) and which way the data flows. Every 16-bit unit has its two bytes exchanged on the way through.

Each word moves in two steps: a read on the source memory, then a write on the destination memory. Both memories sit behind a request/ready handshake. While a copy runs, a busy bit is visible in the control word. When the copy ends, the remaining count reads zero and a one-cycle completion pulse appears.

Some requests finish at once, with no memory traffic and with the pulse in the cycle after the count write:
- a request suppressed by the external mask input;
- an oversized request, which also raises an error flag;
- a zero count;
- a copy from instruction memory toward main memory.

Top module: `dsp_dma_engine`

## Requirements
- R1: Main-memory byte address for unit k is {addr_hi, addr_lo} + 2k. DSP byte address is 2 × (DSP word register) + 2k, truncated to 16 bits.
- R2: Register offsets are 0 = address high, 1 = address low, 2 = DSP word address, 3 = control, 4 = byte count. All read back zero after reset, and each reads back the value written.
- R3: Control bit 2 reads 1 while a copy runs and 0 otherwise. Control bits [15:3] read 0. The count register shows the bytes left and reads 0 once a copy ends.
- R4: If dma_mask is nonzero when the count is written, no memory is accessed. The count reads 0, done pulses in the next cycle, and err stays 0.
- R5: Control bits [1:0] pick the mode. Bit 1 = 1 selects instruction memory (0 selects data memory). Bit 0 = 1 copies DSP memory toward main memory (0 copies main memory into DSP memory).
- R6: Each 16-bit unit is stored at the destination with its high and low bytes exchanged.
- R7: A count above 0x4000 accesses no memory, clears the count, pulses done and sets err. err holds until the next accepted count write. A count of exactly 0x4000 runs in full.
- R8: The main-memory address is masked to 28 bits in instruction-memory modes and to 31 bits in data-memory modes.
- R9: Mode 3 (instruction memory toward main memory) accesses no memory and pulses done in the cycle after the count write.
- R10: Each accepted count write produces exactly one done pulse of one cycle.
- R11: While busy, writes to the address-high, address-low, DSP-address and count registers have no effect.
- R12: An odd count rounds up to whole 16-bit units. A zero count accesses no memory and pulses done at once.
- R13: Only one memory is requested in any cycle. A request keeps its address and write data stable until ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| dma_mask | input | 16 | Nonzero suppresses a launch |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Oversized-count flag |
| mm_req | output | 1 | Main-memory request |
| mm_we | output | 1 | Main-memory write enable |
| mm_addr | output | 32 | Main-memory byte address |
| mm_wdata | output | 16 | Main-memory write data |
| mm_rdata | input | 16 | Main-memory read data, valid with ready |
| mm_ready | input | 1 | Main-memory ready |
| dm_req | output | 1 | DSP-memory request |
| dm_we | output | 1 | DSP-memory write enable |
| dm_imem | output | 1 | 1 selects instruction memory, 0 data memory |
| dm_addr | output | 16 | DSP-memory byte address |
| dm_wdata | output | 16 | DSP-memory write data |
| dm_rdata | input | 16 | DSP-memory read data, valid with ready |
| dm_ready | input | 1 | DSP-memory ready |

## Verification
The hardest case to reach is a register write that lands in the middle of a running copy, which must be dropped. With memories that answer every request at once, a short copy ends before the bench can issue several writes. The bench therefore runs a long copy with both memory models in a slow mode, where ready comes back only about one cycle in four. It confirms the busy bit is set, then writes the address and count registers. After completion it reads back the original register values and checks that the destination holds exactly the first copy's data.

// File: rtl/dsp_dma_engine.sv
module dsp_dma_engine #(
  parameter logic [15:0] MAX_BYTES  = 16'h4000,
  parameter int          IMEM_ABITS = 28,
  parameter int          DMEM_ABITS = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic [15:0] dma_mask,
  output logic        done,
  output logic        err,
  output logic        mm_req,
  output logic        mm_we,
  output logic [31:0] mm_addr,
  output logic [15:0] mm_wdata,
  input  logic [15:0] mm_rdata,
  input  logic        mm_ready,
  output logic        dm_req,
  output logic        dm_we,
  output logic        dm_imem,
  output logic [15:0] dm_addr,
  output logic [15:0] dm_wdata,
  input  logic [15:0] dm_rdata,
  input  logic        dm_ready
);
  localparam logic [2:0]  RA_HI   = 3'd0;
  localparam logic [2:0]  RA_LO   = 3'd1;
  localparam logic [2:0]  RA_DSP  = 3'd2;
  localparam logic [2:0]  RA_CTRL = 3'd3;
  localparam logic [2:0]  RA_LEN  = 3'd4;
  localparam logic [31:0] IMEM_MASK = 32'((64'd1 << IMEM_ABITS) - 64'd1);
  localparam logic [31:0] DMEM_MASK = 32'((64'd1 << DMEM_ABITS) - 64'd1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;

  state_t      st_q;
  logic [15:0] hi_q, lo_q, dsp_q, len_q, off_q, buf_q;
  logic [1:0]  mode_q, run_q;
  logic        done_q, err_q;
  logic        busy, len_wr, over, start, to_cpu, src_ok, dst_ok, last;
  logic [15:0] src_data;
  logic [31:0] mm_base;

  assign busy   = st_q != S_IDLE;
  assign len_wr = reg_wr && reg_addr == RA_LEN && !busy;
  assign over   = reg_wdata > MAX_BYTES;
  assign start  = len_wr && dma_mask == 16'd0 && !over &&
                  reg_wdata != 16'd0 && mode_q != 2'b11;

  assign to_cpu   = run_q[0];
  assign mm_base  = {hi_q, lo_q} + {16'd0, off_q};
  assign mm_addr  = mm_base & (run_q[1] ? IMEM_MASK : DMEM_MASK);
  assign dm_addr  = (dsp_q << 1) + off_q;
  assign dm_imem  = run_q[1];

  assign mm_req   = (st_q == S_READ && !to_cpu) || (st_q == S_WRITE && to_cpu);
  assign dm_req   = (st_q == S_READ && to_cpu)  || (st_q == S_WRITE && !to_cpu);
  assign mm_we    = st_q == S_WRITE;
  assign dm_we    = st_q == S_WRITE;
  assign mm_wdata = buf_q;
  assign dm_wdata = buf_q;

  assign src_data = to_cpu ? dm_rdata : mm_rdata;
  assign src_ok   = to_cpu ? dm_ready : mm_ready;
  assign dst_ok   = to_cpu ? mm_ready : dm_ready;
  assign last     = len_q <= 16'd2;

  assign done = done_q;
  assign err  = err_q;

  always_comb begin
    case (reg_addr)
      RA_HI:   reg_rdata = hi_q;
      RA_LO:   reg_rdata = lo_q;
      RA_DSP:  reg_rdata = dsp_q;
      RA_CTRL: reg_rdata = {13'd0, busy, mode_q};
      RA_LEN:  reg_rdata = len_q;
      default: reg_rdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 16'd0;
      lo_q   <= 16'd0;
      dsp_q  <= 16'd0;
      mode_q <= 2'b00;
    end else if (reg_wr) begin
      if (reg_addr == RA_CTRL) mode_q <= reg_wdata[1:0];
      if (!busy) begin
        if (reg_addr == RA_HI)  hi_q  <= reg_wdata;
        if (reg_addr == RA_LO)  lo_q  <= reg_wdata;
        if (reg_addr == RA_DSP) dsp_q <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      len_q  <= 16'd0;
      off_q  <= 16'd0;
      buf_q  <= 16'd0;
      run_q  <= 2'b00;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start) begin
            st_q  <= S_READ;
            len_q <= reg_wdata;
            off_q <= 16'd0;
            run_q <= mode_q;
            err_q <= 1'b0;
          end else if (len_wr) begin
            len_q  <= 16'd0;
            done_q <= 1'b1;
            err_q  <= dma_mask == 16'd0 && over;
          end
        end
        S_READ: begin
          if (src_ok) begin
            buf_q <= {src_data[7:0], src_data[15:8]};
            st_q  <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (dst_ok) begin
            off_q <= off_q + 16'd2;
            if (last) begin
              len_q  <= 16'd0;
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              len_q <= len_q - 16'd2;
              st_q  <= S_READ;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsp_dma_engine_chk.sv
module dsp_dma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        err,
  input logic        busy,
  input logic        mm_req,
  input logic        mm_ready,
  input logic [31:0] mm_addr,
  input logic [15:0] mm_wdata,
  input logic        dm_req,
  input logic        dm_ready,
  input logic [15:0] dm_addr,
  input logic [15:0] dm_wdata,
  input logic        dm_imem
);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_one_port_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_req && dm_req));
  assert_mm_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req && !mm_ready |=> mm_req && $stable(mm_addr) && $stable(mm_wdata));
  assert_dm_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req && !dm_ready |=> dm_req && $stable(dm_addr) && $stable(dm_wdata));
  assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req || dm_req) |-> busy);
  assert_busy_end_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_imem_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req && dm_imem |-> mm_addr[31:28] == 4'd0);
  assert_dmem_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mm_req |-> !mm_addr[31]);
  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

bind dsp_dma_engine dsp_dma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .busy(busy),
  .mm_req(mm_req), .mm_ready(mm_ready), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
  .dm_req(dm_req), .dm_ready(dm_ready), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
  .dm_imem(dm_imem)
);

// File: tb/test_dsp_dma_engine.sv
module test_dsp_dma_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [15:0] dma_mask = 16'd0;
  logic        done, err;
  logic        mm_req, mm_we, dm_req, dm_we, dm_imem;
  logic [31:0] mm_addr;
  logic [15:0] mm_wdata, mm_rdata, dm_addr, dm_wdata, dm_rdata;
  logic        mm_ready = 1'b0;
  logic        dm_ready = 1'b0;

  dsp_dma_engine i_dsp_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_mask(dma_mask),
    .done(done), .err(err),
    .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_rdata(mm_rdata), .mm_ready(mm_ready),
    .dm_req(dm_req), .dm_we(dm_we), .dm_imem(dm_imem), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .dm_ready(dm_ready)
  );

  logic [15:0] mmem [1024];
  logic [15:0] dmem [512];
  logic [15:0] imem [512];

  assign mm_rdata = mmem[mm_addr[10:1]];
  assign dm_rdata = dm_imem ? imem[dm_addr[9:1]] : dmem[dm_addr[9:1]];

  function automatic logic [15:0] mm_init(input int i);
    return 16'((i * 37 + 4951) ^ (i << 7));
  endfunction
  function automatic logic [15:0] dm_init(input int i);
    return 16'(i * 101 + 41136);
  endfunction
  function automatic logic [15:0] im_init(input int i);
    return 16'(i * 53 + 3085);
  endfunction
  function automatic logic [15:0] swp(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  logic        init_req = 1'b0, clr_mon = 1'b0, slow = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int          hs_cnt = 0, done_cnt = 0;
  logic [3:0]  top_or = 4'd0, top_and = 4'hF;
  int          checks = 0, fails = 0;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (init_req) begin
      for (int i = 0; i < 1024; i++) mmem[i] <= mm_init(i);
      for (int i = 0; i < 512; i++) begin
        dmem[i] <= dm_init(i);
        imem[i] <= im_init(i);
      end
    end else begin
      if (mm_req && mm_ready && mm_we) mmem[mm_addr[10:1]] <= mm_wdata;
      if (dm_req && dm_ready && dm_we) begin
        if (dm_imem) imem[dm_addr[9:1]] <= dm_wdata;
        else         dmem[dm_addr[9:1]] <= dm_wdata;
      end
    end
    mm_ready <= mm_req && !mm_ready && (!slow || lfsr[1:0] == 2'b00);
    dm_ready <= dm_req && !dm_ready && (!slow || lfsr[3:2] == 2'b00);
    if (clr_mon) begin
      hs_cnt <= 0; done_cnt <= 0; top_or <= 4'd0; top_and <= 4'hF;
    end else begin
      if ((mm_req && mm_ready) || (dm_req && dm_ready)) hs_cnt <= hs_cnt + 1;
      if (done) done_cnt <= done_cnt + 1;
      if (mm_req) begin
        top_or  <= top_or | mm_addr[31:28];
        top_and <= top_and & mm_addr[31:28];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic start_xfer(input logic [15:0] hi, lo, dw, input int mode,
                            input logic [15:0] len, mask, output bit imm);
    @(negedge clk);
    init_req = 1'b1; clr_mon = 1'b1;
    @(negedge clk);
    init_req = 1'b0; clr_mon = 1'b0;
    wreg(3'd0, hi);
    wreg(3'd1, lo);
    wreg(3'd2, dw);
    wreg(3'd3, 16'(mode));
    dma_mask = mask;
    wreg(3'd4, len);
    imm = done;
    dma_mask = 16'd0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done_cnt == 0 && n < 100000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, req, "R10 done pulse count", 32'(done_cnt), 32'd1);
  endtask

  task automatic verify(input logic [15:0] lo, dw, input int mode,
                        input logic [15:0] len, input bit run, input string req);
    int nw = run ? (int'(len) + 1) / 2 : 0;
    int mb = int'(lo[10:1]);
    int db = int'(dw[8:0]);
    int bm = 0, bd = 0, bi = 0;
    logic [15:0] e;
    for (int i = 0; i < 1024; i++) begin
      int k = (i - mb + 1024) % 1024;
      e = (mode == 1 && k < nw) ? swp(dm_init((db + k) % 512)) : mm_init(i);
      if (mmem[i] !== e) bm++;
    end
    for (int i = 0; i < 512; i++) begin
      int k = (i - db + 512) % 512;
      e = (mode == 0 && k < nw) ? swp(mm_init((mb + k) % 1024)) : dm_init(i);
      if (dmem[i] !== e) bd++;
      e = (mode == 2 && k < nw) ? swp(mm_init((mb + k) % 1024)) : im_init(i);
      if (imem[i] !== e) bi++;
    end
    chk(bm == 0, req, "main memory mismatches", 32'(bm), 32'd0);
    chk(bd == 0, req, "data memory mismatches", 32'(bd), 32'd0);
    chk(bi == 0, req, "instr memory mismatches", 32'(bi), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] lens [4];
    bit imm;
    lens = '{16'd2, 16'd4, 16'd7, 16'd24};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 5; a++) begin
      rreg(3'(a), v);
      chk(v == 16'd0, "R2", "reset register value", 32'(v), 32'd0);
    end
    chk(done == 1'b0, "R10", "reset done", 32'(done), 32'd0);
    chk(err == 1'b0, "R7", "reset err", 32'(err), 32'd0);

    wreg(3'd0, 16'h1234); wreg(3'd1, 16'h5678); wreg(3'd2, 16'h0042); wreg(3'd3, 16'h0002);
    rreg(3'd0, v); chk(v == 16'h1234, "R2", "addr hi readback", 32'(v), 32'h1234);
    rreg(3'd1, v); chk(v == 16'h5678, "R2", "addr lo readback", 32'(v), 32'h5678);
    rreg(3'd2, v); chk(v == 16'h0042, "R2", "dsp addr readback", 32'(v), 32'h0042);
    rreg(3'd3, v); chk(v == 16'h0002, "R2", "ctrl readback", 32'(v), 32'h0002);
    wreg(3'd3, 16'hFFFF);
    rreg(3'd3, v); chk(v == 16'h0003, "R3", "ctrl upper bits and idle busy", 32'(v), 32'h0003);

    // R1 R5 R6 R12: sweep over modes, lengths and start addresses
    for (int m = 0; m < 4; m++) begin
      for (int li = 0; li < 4; li++) begin
        logic [15:0] lo = 16'(16'h0100 + m * 64 + li * 5);
        logic [15:0] dw = 16'(20 + m * 30 + li * 7);
        start_xfer(16'h0003, lo, dw, m, lens[li], 16'd0, imm);
        if (m == 3) chk(imm == 1'b1, "R9", "no-op immediate done", 32'(imm), 32'd1);
        wait_done("R5");
        if (m == 3) chk(hs_cnt == 0, "R9", "no-op memory accesses", 32'(hs_cnt), 32'd0);
        else chk(hs_cnt == 2 * ((int'(lens[li]) + 1) / 2), "R12", "handshakes for count",
                 32'(hs_cnt), 32'(2 * ((int'(lens[li]) + 1) / 2)));
        verify(lo, dw, m, lens[li], m != 3, "R6");
        rreg(3'd4, v); chk(v == 16'd0, "R3", "count after copy", 32'(v), 32'd0);
        rreg(3'd3, v); chk(v[2] == 1'b0, "R3", "busy after copy", 32'(v[2]), 32'd0);
      end
    end

    start_xfer(16'h0, 16'h0020, 16'h0008, 0, 16'd0, 16'd0, imm);
    chk(imm == 1'b1, "R12", "zero count immediate done", 32'(imm), 32'd1);
    wait_done("R12");
    chk(hs_cnt == 0, "R12", "zero count accesses", 32'(hs_cnt), 32'd0);
    verify(16'h0020, 16'h0008, 0, 16'd0, 1'b0, "R12");

    start_xfer(16'h0, 16'h0020, 16'h0008, 0, 16'd8, 16'h0001, imm);
    chk(imm == 1'b1, "R4", "masked immediate done", 32'(imm), 32'd1);
    wait_done("R4");
    chk(hs_cnt == 0, "R4", "masked accesses", 32'(hs_cnt), 32'd0);
    verify(16'h0020, 16'h0008, 0, 16'd8, 1'b0, "R4");
    rreg(3'd4, v); chk(v == 16'd0, "R4", "masked count cleared", 32'(v), 32'd0);
    chk(err == 1'b0, "R4", "masked err", 32'(err), 32'd0);

    start_xfer(16'h0, 16'h0020, 16'h0008, 0, 16'h4001, 16'd0, imm);
    wait_done("R7");
    chk(err == 1'b1, "R7", "oversize err", 32'(err), 32'd1);
    chk(hs_cnt == 0, "R7", "oversize accesses", 32'(hs_cnt), 32'd0);
    rreg(3'd4, v); chk(v == 16'd0, "R7", "oversize count cleared", 32'(v), 32'd0);
    start_xfer(16'h0, 16'h0020, 16'h0008, 0, 16'd4, 16'd0, imm);
    wait_done("R7");
    chk(err == 1'b0, "R7", "err cleared by next copy", 32'(err), 32'd0);

    start_xfer(16'h0, 16'h0000, 16'h0000, 0, 16'h4000, 16'd0, imm);
    wait_done("R7");
    chk(err == 1'b0, "R7", "max count err", 32'(err), 32'd0);
    chk(hs_cnt == 16384, "R7", "max count handshakes", 32'(hs_cnt), 32'd16384);

    start_xfer(16'hFFFF, 16'h0010, 16'h0005, 2, 16'd6, 16'd0, imm);
    wait_done("R8");
    chk(top_or == 4'd0, "R8", "instr mode top address bits", 32'(top_or), 32'd0);
    verify(16'h0010, 16'h0005, 2, 16'd6, 1'b1, "R8");
    start_xfer(16'hFFFF, 16'h0010, 16'h0005, 0, 16'd6, 16'd0, imm);
    wait_done("R8");
    chk(top_or == 4'h7 && top_and == 4'h7, "R8", "data mode top address bits",
        32'({top_or, top_and}), 32'h77);

    slow = 1'b1;
    start_xfer(16'h0, 16'h0040, 16'h0010, 0, 16'd32, 16'd0, imm);
    repeat (3) @(negedge clk);
    rreg(3'd3, v); chk(v[2] == 1'b1, "R3", "busy during copy", 32'(v[2]), 32'd1);
    rreg(3'd4, v); chk(v != 16'd0, "R3", "count nonzero during copy", 32'(v), 32'd1);
    wreg(3'd1, 16'hBEEF);
    wreg(3'd4, 16'd2);
    wreg(3'd2, 16'h0100);
    wreg(3'd0, 16'h0055);
    rreg(3'd3, v); chk(v[2] == 1'b1, "R11", "still busy after writes", 32'(v[2]), 32'd1);
    wait_done("R11");
    slow = 1'b0;
    rreg(3'd1, v); chk(v == 16'h0040, "R11", "addr lo kept", 32'(v), 32'h0040);
    rreg(3'd2, v); chk(v == 16'h0010, "R11", "dsp addr kept", 32'(v), 32'h0010);
    rreg(3'd0, v); chk(v == 16'h0000, "R11", "addr hi kept", 32'(v), 32'h0000);
    rreg(3'd4, v); chk(v == 16'd0, "R11", "count after copy", 32'(v), 32'd0);
    verify(16'h0040, 16'h0010, 0, 16'd32, 1'b1, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule